// File: doc/BRIEF.md
# Prioritized UART Interrupt and Modem-Status Unit

This block merges the four interrupt causes of an asynchronous serial port into one active-high request line and an identification byte. The four causes are receive-line errors, received data waiting, transmit holding register empty, and modem-line change. Only the most urgent cause that is both pending and enabled is identified. The line-error and receive causes follow status flags that logic elsewhere produces. The transmit-empty cause is an event the block arms itself, and reading the identification byte while it is reported acknowledges it.

The block also keeps the modem-status byte. The low nibble holds sticky change flags and the high nibble shows the present line levels. It drives the four active-low modem-control outputs from the control bits. In loopback it feeds those control bits back as the line levels, ignores the external pins and parks the external outputs high. Reset is synchronous and active high. Every output is registered, so it shows the inputs sampled at the previous rising clock edge.

Top module: `irq_modem_unit`

## Requirements
- R1: While reset is sampled high, the next cycle shows irq = 0, identification byte 0x01, change flags (status bits 3..0) = 0, and all four modem outputs = 1.
- R2: The identification byte reports the highest-priority pending enabled cause in bits 3..0. The codes are 0110 for a line error (highest), 0100 for receive data, 0010 for transmit empty and 0000 for modem change (lowest). With no cause it reports 0001. Bits 7..4 are always 0.
- R3: Enable bit 0 gates receive data, bit 1 gates transmit empty, bit 2 gates line errors and bit 3 gates modem change. A cause whose enable is 0 is neither reported nor raises irq.
- R4: irq is 1 exactly when some enabled cause is pending, which is when identification bit 0 is 0.
- R5: The transmit-empty cause is armed by a 0-to-1 change of the holding-empty flag or of enable bit 1. A holding-register write strobe clears it.
- R6: An identification read strobe clears the transmit-empty cause only while code 0010 is being reported. A read while another code is reported leaves every cause unchanged. Line-error and receive causes stay pending while their flags stay set.
- R7: Change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) set whenever that line's level changes. A status read strobe clears all flags, but a change in the same cycle as the read stays set.
- R8: The RI change flag (bit 2) sets only when the active-low ring pin goes from 0 to 1, and never when it goes from 1 to 0.
- R9: Status bits 4, 5, 6 and 7 show CTS, DSR, RI and CD as the complements of the active-low pins.
- R10: In loopback, CTS takes control bit 1, DSR takes control bit 0, RI takes control bit 2 and CD takes control bit 3. The pins have no effect, and all four external modem outputs read 1.
- R11: Outside loopback, control bits 0, 1, 2 and 3 drive dtr_n, rts_n, op1_n and op2_n inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lsr_overrun | input | 1 | Receive overrun flag |
| lsr_parity_err | input | 1 | Parity error flag |
| lsr_frame_err | input | 1 | Framing error flag |
| lsr_break | input | 1 | Break-received flag |
| lsr_data_ready | input | 1 | Receive data waiting |
| lsr_thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Holding-register write strobe |
| ier_mask | input | 4 | Cause enables |
| id_rd | input | 1 | Identification read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| mcr_bits | input | 4 | Control bits: DTR, RTS, OP1, OP2 |
| loopback | input | 1 | Loopback mode select |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| cd_n | input | 1 | Carrier pin, active low |
| id_reg | output | 8 | Identification byte |
| msr_reg | output | 8 | Modem-status byte |
| irq | output | 1 | Interrupt request |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| op1_n | output | 1 | User output 1, active low |
| op2_n | output | 1 | User output 2, active low |

## Verification
The directed part stacks causes on top of one another, so that each code must yield to a higher one and reappear when that one drops. It reads the identification byte under a line-error code and under a transmit-empty code, which separates an acknowledge that clears only its own cause from one that clears any cause. On the modem side, each line is toggled in both directions, a change is made in the same cycle as a status read, and loopback is entered with a mixed control pattern, which exposes any swapped mapping or wrong edge sense on the ring flag. A randomized phase then drives every input, and a behavioural model checks all outputs on every cycle.

// File: rtl/uim_pkg.sv
package uim_pkg;

    localparam int NLINES = 4;
    localparam int NSRC   = 4;
    localparam int IDW    = 4;
    localparam int BYTEW  = 8;

    // line index: also the bit position inside the status byte nibbles
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_CD  = 3;

    // enable / cause index
    localparam int S_RX  = 0;
    localparam int S_TX  = 1;
    localparam int S_LS  = 2;
    localparam int S_MS  = 3;

    typedef enum logic [IDW-1:0] {
        ID_LINE  = 4'b0110,
        ID_RXRDY = 4'b0100,
        ID_THRE  = 4'b0010,
        ID_MODEM = 4'b0000,
        ID_NONE  = 4'b0001
    } irq_id_e;

    typedef struct packed {
        logic [NLINES-1:0] lvl;
        logic [NLINES-1:0] delta;
        logic [NLINES-1:0] outn;
    } modem_st_t;

    typedef struct packed {
        logic    tx_arm;
        logic    thre_seen;
        logic    tx_en_seen;
        irq_id_e id;
        logic    irq;
    } prio_st_t;

    // which control bit feeds each line during loopback
    function automatic int lb_src(input int line);
        case (line)
            L_CTS:   return 1;
            L_DSR:   return 0;
            L_RI:    return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/uim_modem.sv
module uim_modem
    import uim_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] mcr,
    input  logic         loopback,
    input  logic         msr_rd,
    output logic [2*N-1:0] msr_out,
    output logic [N-1:0] delta_nx,
    output logic [N-1:0] mctl_n
);

    modem_st_t q, d;
    logic [N-1:0] lvl_now;
    logic [N-1:0] chg;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign lvl_now[g] = loopback ? mcr[lb_src(g)] : ~pin_n[g];
        if (g == L_RI) begin : g_trail
            // active-high level falling == pin rising
            assign chg[g] = q.lvl[g] & ~lvl_now[g];
        end else begin : g_any
            assign chg[g] = q.lvl[g] ^ lvl_now[g];
        end
    end

    always_comb begin
        d       = q;
        d.lvl   = lvl_now;
        d.delta = (msr_rd ? '0 : q.delta) | chg;
        d.outn  = loopback ? '1 : ~mcr;
        if (rst) begin
            d.lvl   = lvl_now;
            d.delta = '0;
            d.outn  = '1;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign msr_out  = {q.lvl, q.delta};
    assign delta_nx = d.delta;
    assign mctl_n   = q.outn;

endmodule

// File: rtl/uim_prio.sv
module uim_prio
    import uim_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_err,
    input  logic          rx_ready,
    input  logic          thr_empty,
    input  logic          thr_wr,
    input  logic          id_rd,
    input  logic [NS-1:0] ier,
    input  logic          modem_pend,
    output logic [BYTEW-1:0] id_out,
    output logic          irq
);

    prio_st_t q, d;
    logic [NS-1:0] pend;
    logic [NS-1:0] act;
    logic tx_set, tx_clr;

    always_comb begin
        d = q;
        tx_set = (thr_empty & ~q.thre_seen) | (ier[S_TX] & ~q.tx_en_seen);
        tx_clr = thr_wr | (id_rd & (q.id == ID_THRE));
        d.thre_seen  = thr_empty;
        d.tx_en_seen = ier[S_TX];
        if (tx_set)      d.tx_arm = 1'b1;
        else if (tx_clr) d.tx_arm = 1'b0;

        pend         = '0;
        pend[S_RX]   = rx_ready;
        pend[S_TX]   = d.tx_arm;
        pend[S_LS]   = line_err;
        pend[S_MS]   = modem_pend;
        act          = pend & ier;

        d.irq = |act;
        if (act[S_LS])      d.id = ID_LINE;
        else if (act[S_RX]) d.id = ID_RXRDY;
        else if (act[S_TX]) d.id = ID_THRE;
        else if (act[S_MS]) d.id = ID_MODEM;
        else                d.id = ID_NONE;

        if (rst) begin
            d.tx_arm     = 1'b0;
            d.thre_seen  = thr_empty;
            d.tx_en_seen = ier[S_TX];
            d.id         = ID_NONE;
            d.irq        = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign id_out = {{(BYTEW-IDW){1'b0}}, q.id};
    assign irq    = q.irq;

endmodule

// File: rtl/irq_modem_unit.sv
module irq_modem_unit
    import uim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lsr_overrun,
    input  logic       lsr_parity_err,
    input  logic       lsr_frame_err,
    input  logic       lsr_break,
    input  logic       lsr_data_ready,
    input  logic       lsr_thr_empty,
    input  logic       thr_wr,
    input  logic [3:0] ier_mask,
    input  logic       id_rd,
    input  logic       msr_rd,
    input  logic [3:0] mcr_bits,
    input  logic       loopback,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    output logic [7:0] id_reg,
    output logic [7:0] msr_reg,
    output logic       irq,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       op1_n,
    output logic       op2_n
);

    logic [NLINES-1:0] pins_n;
    logic [NLINES-1:0] delta_nx;
    logic [NLINES-1:0] mctl_n;
    logic              line_err;

    always_comb begin
        pins_n        = '1;
        pins_n[L_CTS] = cts_n;
        pins_n[L_DSR] = dsr_n;
        pins_n[L_RI]  = ri_n;
        pins_n[L_CD]  = cd_n;
    end

    assign line_err = lsr_overrun | lsr_parity_err | lsr_frame_err | lsr_break;

    uim_modem #(.N(NLINES)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (pins_n),
        .mcr      (mcr_bits),
        .loopback (loopback),
        .msr_rd   (msr_rd),
        .msr_out  (msr_reg),
        .delta_nx (delta_nx),
        .mctl_n   (mctl_n)
    );

    uim_prio #(.NS(NSRC)) u_prio (
        .clk        (clk),
        .rst        (rst),
        .line_err   (line_err),
        .rx_ready   (lsr_data_ready),
        .thr_empty  (lsr_thr_empty),
        .thr_wr     (thr_wr),
        .id_rd      (id_rd),
        .ier        (ier_mask),
        .modem_pend (|delta_nx),
        .id_out     (id_reg),
        .irq        (irq)
    );

    assign dtr_n = mctl_n[0];
    assign rts_n = mctl_n[1];
    assign op1_n = mctl_n[2];
    assign op2_n = mctl_n[3];

endmodule

// File: rtl/irq_modem_unit_chk.sv
module irq_modem_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ier_mask,
    input logic       loopback,
    input logic [7:0] id_reg,
    input logic [7:0] msr_reg,
    input logic       irq,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       op1_n,
    input logic       op2_n
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!irq && id_reg == 8'h01 && msr_reg[3:0] == 4'h0 &&
                 {op2_n, op1_n, rts_n, dtr_n} == 4'hF));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        id_reg[7:4] == 4'h0);

    a_r3_line_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (id_reg[3:0] == 4'b0110) |-> $past(ier_mask[2]));

    a_r4_irq_vs_id: assert property (@(posedge clk) disable iff (rst)
        irq == !id_reg[0]);

    a_r8_ri_trailing: assert property (@(posedge clk) disable iff (rst)
        $rose(msr_reg[2]) |-> $fell(msr_reg[6]));

    a_r10_loop_outs_high: assert property (@(posedge clk) disable iff (rst)
        $past(loopback) |-> ({op2_n, op1_n, rts_n, dtr_n} == 4'hF));

endmodule

bind irq_modem_unit irq_modem_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ier_mask (ier_mask),
    .loopback (loopback),
    .id_reg   (id_reg),
    .msr_reg  (msr_reg),
    .irq      (irq),
    .dtr_n    (dtr_n),
    .rts_n    (rts_n),
    .op1_n    (op1_n),
    .op2_n    (op2_n)
);

// File: tb/sim_irq_modem_unit.sv
module sim_irq_modem_unit;

    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lsr_overrun = 0, lsr_parity_err = 0, lsr_frame_err = 0, lsr_break = 0;
    logic lsr_data_ready = 0, lsr_thr_empty = 1, thr_wr = 0;
    logic [3:0] ier_mask = 4'h0;
    logic id_rd = 0, msr_rd = 0;
    logic [3:0] mcr_bits = 4'h0;
    logic loopback = 0;
    logic cts_n = 1, dsr_n = 1, ri_n = 1, cd_n = 1;
    logic [7:0] id_reg, msr_reg;
    logic irq, dtr_n, rts_n, op1_n, op2_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_NS/2) clk = ~clk;

    irq_modem_unit u0 (
        .clk(clk), .rst(rst),
        .lsr_overrun(lsr_overrun), .lsr_parity_err(lsr_parity_err),
        .lsr_frame_err(lsr_frame_err), .lsr_break(lsr_break),
        .lsr_data_ready(lsr_data_ready), .lsr_thr_empty(lsr_thr_empty),
        .thr_wr(thr_wr), .ier_mask(ier_mask), .id_rd(id_rd), .msr_rd(msr_rd),
        .mcr_bits(mcr_bits), .loopback(loopback),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .id_reg(id_reg), .msr_reg(msr_reg), .irq(irq),
        .dtr_n(dtr_n), .rts_n(rts_n), .op1_n(op1_n), .op2_n(op2_n)
    );

    // behavioural reference model
    logic [3:0] m_lvl, m_dl, m_out, lv, ch;
    logic       m_tx, m_thre, m_en1, m_irq, arm, clr, errs;
    logic [7:0] m_id;

    always @(posedge clk) begin
        lv = loopback ? {mcr_bits[3], mcr_bits[2], mcr_bits[0], mcr_bits[1]}
                      : ~{cd_n, ri_n, dsr_n, cts_n};
        errs = lsr_overrun | lsr_parity_err | lsr_frame_err | lsr_break;
        if (rst) begin
            m_lvl = lv; m_dl = 0; m_out = 4'hF; m_tx = 0;
            m_thre = lsr_thr_empty; m_en1 = ier_mask[1];
            m_id = 8'h01; m_irq = 0;
        end else begin
            ch = ((m_lvl ^ lv) & 4'b1011) | ((m_lvl & ~lv) & 4'b0100);
            m_dl = (msr_rd ? 4'h0 : m_dl) | ch;
            m_lvl = lv;
            m_out = loopback ? 4'hF : ~mcr_bits;
            arm = (lsr_thr_empty && !m_thre) || (ier_mask[1] && !m_en1);
            clr = thr_wr || (id_rd && m_id == 8'h02);
            if (arm) m_tx = 1; else if (clr) m_tx = 0;
            m_thre = lsr_thr_empty; m_en1 = ier_mask[1];
            if (ier_mask[2] && errs)               m_id = 8'h06;
            else if (ier_mask[0] && lsr_data_ready) m_id = 8'h04;
            else if (ier_mask[1] && m_tx)           m_id = 8'h02;
            else if (ier_mask[3] && m_dl != 0)      m_id = 8'h00;
            else                                    m_id = 8'h01;
            m_irq = (m_id != 8'h01);
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (!rst) begin
            chk("R2 id vs model", id_reg, m_id);
            chk("R7 status vs model", msr_reg, {m_lvl, m_dl});
            chk("R4 irq vs model", {7'b0, irq}, {7'b0, m_irq});
            chk("R11 outputs vs model", {4'b0, op2_n, op1_n, rts_n, dtr_n}, {4'b0, m_out});
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        step(); step();
        // R1 reset state (still in reset)
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 id", id_reg, 8'h01);
        chk("R1 deltas", {4'b0, msr_reg[3:0]}, 8'h00);
        chk("R1 outputs", {4'b0, op2_n, op1_n, rts_n, dtr_n}, 8'h0F);
        rst = 0;
        step();

        // R5 enable rise arms transmit-empty
        ier_mask = 4'hF; step();
        chk("R5 enable arms", id_reg, 8'h02);
        chk("R4 irq high", {7'b0, irq}, 8'h01);
        // R6 acknowledge by id read
        id_rd = 1; step(); id_rd = 0;
        chk("R6 id read clears tx", id_reg, 8'h01);
        chk("R4 irq low", {7'b0, irq}, 8'h00);

        // R2 priority stacking
        lsr_data_ready = 1; step();
        chk("R2 receive code", id_reg, 8'h04);
        lsr_parity_err = 1; step();
        chk("R2 line code wins", id_reg, 8'h06);
        id_rd = 1; step(); id_rd = 0;
        chk("R6 read keeps line cause", id_reg, 8'h06);
        lsr_parity_err = 0; step();
        chk("R6 lower becomes visible", id_reg, 8'h04);
        lsr_data_ready = 0; step();
        chk("R2 none", id_reg, 8'h01);

        // R5 holding-empty rise and write clear
        lsr_thr_empty = 0; step();
        lsr_thr_empty = 1; step();
        chk("R5 empty rise arms", id_reg, 8'h02);
        thr_wr = 1; step(); thr_wr = 0;
        chk("R5 write clears", id_reg, 8'h01);

        // R3 masked causes
        ier_mask = 4'b1010; lsr_data_ready = 1; lsr_break = 1; step();
        chk("R3 masked receive/line", id_reg, 8'h01);
        chk("R3 masked irq", {7'b0, irq}, 8'h00);
        lsr_data_ready = 0; lsr_break = 0; ier_mask = 4'hF; step();

        // R7 / R9 modem lines
        cts_n = 0; step();
        chk("R9 R7 cts change", msr_reg, 8'h11);
        chk("R2 modem code", id_reg, 8'h00);
        msr_rd = 1; step(); msr_rd = 0;
        chk("R7 read clears", msr_reg, 8'h10);
        dsr_n = 0; cd_n = 0; step();
        chk("R9 R7 dsr cd", msr_reg, 8'hBA);
        msr_rd = 1; cts_n = 1; step(); msr_rd = 0;
        chk("R7 change during read kept", msr_reg, 8'hA1);

        // R8 ring edge sense
        msr_rd = 1; ri_n = 0; step(); msr_rd = 0;
        chk("R8 no flag on ring assert", msr_reg, 8'hE0);
        ri_n = 1; step();
        chk("R8 flag on ring release", msr_reg, 8'hA4);
        msr_rd = 1; step(); msr_rd = 0;
        chk("R7 cleared", msr_reg, 8'hA0);

        // R11 outputs
        mcr_bits = 4'b0101; step();
        chk("R11 outputs", {4'b0, op2_n, op1_n, rts_n, dtr_n}, 8'h0A);

        // R10 loopback
        loopback = 1; step();
        chk("R10 loop levels", msr_reg, 8'h68);
        chk("R10 outputs parked", {4'b0, op2_n, op1_n, rts_n, dtr_n}, 8'h0F);
        cts_n = 0; step();
        chk("R10 pins ignored", msr_reg, 8'h68);
        mcr_bits = 4'b0010; step();
        chk("R10 remap", msr_reg, 8'h1F);
        loopback = 0; msr_rd = 1; step(); msr_rd = 0;
        chk("R11 leave loopback", {7'b0, rts_n}, 8'h00);

        // randomized phase
        for (int i = 0; i < 400; i++) begin
            lsr_overrun    = ($urandom_range(0, 15) == 0);
            lsr_parity_err = ($urandom_range(0, 15) == 0);
            lsr_frame_err  = ($urandom_range(0, 15) == 0);
            lsr_break      = ($urandom_range(0, 15) == 0);
            lsr_data_ready = ($urandom_range(0, 3) == 0);
            lsr_thr_empty  = ($urandom_range(0, 2) != 0);
            thr_wr         = ($urandom_range(0, 7) == 0);
            id_rd          = ($urandom_range(0, 3) == 0);
            msr_rd         = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 7) == 0) ier_mask = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) mcr_bits = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 31) == 0) loopback = ~loopback;
            cts_n = ($urandom_range(0, 4) != 0) ? cts_n : ~cts_n;
            dsr_n = ($urandom_range(0, 4) != 0) ? dsr_n : ~dsr_n;
            ri_n  = ($urandom_range(0, 4) != 0) ? ri_n  : ~ri_n;
            cd_n  = ($urandom_range(0, 4) != 0) ? cd_n  : ~cd_n;
            step();
        end
        summary();
    end

endmodule